// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block finishes a transfer on an I2C bus by producing the stop condition for a master controller. Once a byte and its acknowledge are done, the surrounding controller pulses a "transfer finished" input and the block keeps SCL pulled low. Software then sets the stop-enable bit, and the block runs a closed-loop sequence. It pulls SDA low, then releases SCL, then releases SDA. Each phase begins only when the line it depends on is read back from the bus at the expected level. Each timed phase lasts one full period of an included baud rate generator.

When SDA reads high while SCL is high, the stop-enable bit clears itself, a stop-detected status bit is set and a sticky interrupt flag is raised, so a controller waiting for a free bus learns of it. While the sequence runs, any write to the data buffer is refused: the buffer keeps its value and a sticky write-collision flag is set. Both lines are open-drain. The block drives only "pull low" enables and reads the wired bus level back.

Top module: `i2c_stop_sequencer`

## Requirements
- R1: After reset both pull-low outputs are 0, and stop-enable, stop-detected, interrupt and write-collision are all 0.
- R2: One cycle after a `xferDone` pulse, `sclPullLow` is 1. It stays 1 with SDA released until a stop sequence releases it.
- R3: In the cycle after `stopReq` is sampled with the block idle, `stopEnable`, `sdaPullLow` and `sclPullLow` are all 1. This holds even when no transfer finished first.
- R4: With reload value N, `sclPullLow` drops N+2 cycles after `sdaPullLow` rises. That is one cycle to read SDA low plus a generator period of N+1 cycles.
- R5: `sdaPullLow` drops N+2 cycles after SCL reads high: one sampling cycle plus one generator period. SDA is never released while the block still pulls SCL low.
- R6: While a released SCL reads low (a slave holding it), the generator is not reloaded and the sequence waits. Every cycle of holding delays the SDA release and the completion by one cycle.
- R7: One cycle after SDA reads high with SCL high, `stopEnable` returns to 0, and `stopDetected` and `irqFlag` become 1.
- R8: `irqFlag` stays 1 until an `irqClear` pulse. `stopDetected` stays 1 until a `startSeen` pulse and is not affected by `irqClear`.
- R9: A `bufWrite` while `stopEnable` is 1 leaves `bufData` unchanged and sets `wcolFlag`. A write while idle loads `bufWrData` into `bufData` and leaves `wcolFlag` at 0.
- R10: `wcolFlag` stays 1 until a `wcolClear` pulse.
- R11: A `stopReq` while a sequence is running is ignored, and the sequence timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reloadVal | input | BRG_W | Baud rate generator reload count N (period N+1 cycles) |
| xferDone | input | 1 | Pulse: ninth clock fell, hold SCL low |
| stopReq | input | 1 | Pulse: software sets the stop-enable bit |
| startSeen | input | 1 | Pulse: a start condition was detected, clears stop-detected |
| irqClear | input | 1 | Pulse: software clears the interrupt flag |
| wcolClear | input | 1 | Pulse: software clears the write-collision flag |
| bufWrite | input | 1 | Pulse: software writes the data buffer |
| bufWrData | input | DATA_W | Data for a buffer write |
| sclIn | input | 1 | SCL level read back from the bus |
| sdaIn | input | 1 | SDA level read back from the bus |
| sclPullLow | output | 1 | Open-drain enable: pull SCL low |
| sdaPullLow | output | 1 | Open-drain enable: pull SDA low |
| stopEnable | output | 1 | Stop-enable bit, self-clearing |
| stopDetected | output | 1 | Stop-detected status bit |
| irqFlag | output | 1 | Interrupt flag |
| wcolFlag | output | 1 | Write-collision flag |
| bufData | output | DATA_W | Data buffer contents |

## Verification
The stop is run with every reload value from 0 to 7 on a 4-bit generator. The phase edges are measured in cycles, so an off-by-one in the sampling cycle or the period shows up as a different slope against N. Each reload value is run both with a free bus and with a slave holding SCL low for three cycles. This separates a sequencer that waits on the read-back level from one that only counts time. Further runs inject a buffer write and a repeated stop request mid-sequence, and pulse the clear and start inputs. These show that the collision path, the sticky flags and the ignore rule act independently.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LOW,
    ST_WAIT_SCL,
    ST_SCL_HIGH,
    ST_WAIT_SDA,
    ST_SDA_HIGH
  } stopState_t;

  typedef struct packed {
    logic brgLoad;
    logic brgRun;
    logic pullScl;
    logic pullSda;
    logic seqDone;
    logic busy;
  } stopStrobes_t;

endpackage

// File: rtl/i2c_stop_ctrl.sv
module i2c_stop_ctrl
  import i2c_stop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stopReq,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         brgZero,
  output stopStrobes_t strb
);

  stopState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.busy = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        // R11: requests are only taken here
        if (stopReq) stateNext = ST_SDA_LOW;
      end
      ST_SDA_LOW: begin
        strb.pullScl = 1'b1;
        strb.pullSda = 1'b1;
        if (!sdaIn) begin
          strb.brgLoad = 1'b1;
          stateNext    = ST_WAIT_SCL;
        end
      end
      ST_WAIT_SCL: begin
        strb.pullScl = 1'b1;
        strb.pullSda = 1'b1;
        strb.brgRun  = 1'b1;
        if (brgZero) stateNext = ST_SCL_HIGH;
      end
      ST_SCL_HIGH: begin
        strb.pullSda = 1'b1;
        // R6: no reload until SCL is actually high
        if (sclIn) begin
          strb.brgLoad = 1'b1;
          stateNext    = ST_WAIT_SDA;
        end
      end
      ST_WAIT_SDA: begin
        strb.pullSda = 1'b1;
        strb.brgRun  = 1'b1;
        if (brgZero) stateNext = ST_SDA_HIGH;
      end
      ST_SDA_HIGH: begin
        if (sclIn && sdaIn) begin
          strb.seqDone = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R7: the sequence ends only after both lines were read high
  p_done_lines_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.busy) |-> ($past(sclIn) && $past(sdaIn)));

  // R4: the timed SCL-low phase is entered only from the SDA-low phase
  p_wait_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_SCL) |-> ($past(state) == ST_SDA_LOW || $past(state) == ST_WAIT_SCL));

endmodule

// File: rtl/i2c_stop_datapath.sv
module i2c_stop_datapath
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stopStrobes_t      strb,
  input  logic [BRG_W-1:0]  reloadVal,
  input  logic              xferDone,
  input  logic              startSeen,
  input  logic              irqClear,
  input  logic              wcolClear,
  input  logic              bufWrite,
  input  logic [DATA_W-1:0] bufWrData,
  output logic              brgZero,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic              stopDetected,
  output logic              irqFlag,
  output logic              wcolFlag,
  output logic [DATA_W-1:0] bufData
);

  localparam logic [BRG_W-1:0] BRG_ONE = BRG_W'(1);

  logic [BRG_W-1:0]  brgCnt;
  logic [DATA_W-1:0] bufReg;
  logic              sclHold;

  // Baud rate generator: period is reload + 1 cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    brgCnt <= '0;
    else if (strb.brgLoad)        brgCnt <= reloadVal;
    else if (strb.brgRun && !brgZero) brgCnt <= brgCnt - BRG_ONE;
  end
  assign brgZero = (brgCnt == '0);

  // SCL held low after the ninth clock until the sequencer owns the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sclHold <= 1'b0;
    else if (xferDone)  sclHold <= 1'b1;
    else if (strb.busy) sclHold <= 1'b0;
  end

  assign sclPullLow = sclHold | strb.pullScl;
  assign sdaPullLow = strb.pullSda;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopDetected <= 1'b0;
      irqFlag      <= 1'b0;
      wcolFlag     <= 1'b0;
      bufReg       <= '0;
    end else begin
      if (strb.seqDone)  stopDetected <= 1'b1;
      else if (startSeen) stopDetected <= 1'b0;
      if (strb.seqDone)  irqFlag <= 1'b1;
      else if (irqClear) irqFlag <= 1'b0;
      if (bufWrite && strb.busy) wcolFlag <= 1'b1;
      else if (wcolClear)        wcolFlag <= 1'b0;
      if (bufWrite && !strb.busy) bufReg <= bufWrData;
    end
  end
  assign bufData = bufReg;

  p_hold_scl_r2: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> sclPullLow);

  p_sda_after_scl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclPullLow);

  p_irq_with_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> stopDetected);

  p_buf_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && bufWrite) |=> ($stable(bufReg) && wcolFlag));

endmodule

// File: rtl/i2c_stop_sequencer.sv
module i2c_stop_sequencer
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BRG_W-1:0]  reloadVal,
  input  logic              xferDone,
  input  logic              stopReq,
  input  logic              startSeen,
  input  logic              irqClear,
  input  logic              wcolClear,
  input  logic              bufWrite,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic              stopEnable,
  output logic              stopDetected,
  output logic              irqFlag,
  output logic              wcolFlag,
  output logic [DATA_W-1:0] bufData
);

  stopStrobes_t strb;
  logic         brgZero;

  i2c_stop_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stopReq (stopReq),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .brgZero (brgZero),
    .strb    (strb)
  );

  i2c_stop_datapath #(.BRG_W(BRG_W), .DATA_W(DATA_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reloadVal    (reloadVal),
    .xferDone     (xferDone),
    .startSeen    (startSeen),
    .irqClear     (irqClear),
    .wcolClear    (wcolClear),
    .bufWrite     (bufWrite),
    .bufWrData    (bufWrData),
    .brgZero      (brgZero),
    .sclPullLow   (sclPullLow),
    .sdaPullLow   (sdaPullLow),
    .stopDetected (stopDetected),
    .irqFlag      (irqFlag),
    .wcolFlag     (wcolFlag),
    .bufData      (bufData)
  );

  assign stopEnable = strb.busy;

endmodule

// File: tb/test_i2c_stop_sequencer.sv
`timescale 1ns/1ps
module test_i2c_stop_sequencer;

  localparam int BW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BW-1:0] reloadVal = '0;
  logic xferDone = 0, stopReq = 0, startSeen = 0, irqClear = 0, wcolClear = 0, bufWrite = 0;
  logic [DW-1:0] bufWrData = '0;
  logic slaveHold = 1'b0;
  logic sclIn, sdaIn, sclPullLow, sdaPullLow, stopEnable, stopDetected, irqFlag, wcolFlag;
  logic [DW-1:0] bufData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign sclIn = !sclPullLow && !slaveHold;
  assign sdaIn = !sdaPullLow;

  i2c_stop_sequencer #(.BRG_W(BW), .DATA_W(DW)) i_i2c_stop_sequencer (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .xferDone(xferDone),
    .stopReq(stopReq), .startSeen(startSeen), .irqClear(irqClear),
    .wcolClear(wcolClear), .bufWrite(bufWrite), .bufWrData(bufWrData),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .stopEnable(stopEnable), .stopDetected(stopDetected), .irqFlag(irqFlag),
    .wcolFlag(wcolFlag), .bufData(bufData));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  // One stop sequence with reload n and a slave holding SCL for h cycles
  task automatic runStop(input int n, input int h, input bit doWrite, input bit doReq, input bit afterXfer);
    int sdaLowAt = -1, sclRelAt = -1, sdaRelAt = -1, doneAt = -1;
    bit prevScl, prevSda, reqSeen;
    reloadVal = BW'(n);
    if (afterXfer) begin
      pulse(xferDone);
      check(sclPullLow == 1, "R2 scl held after transfer", int'(sclPullLow), 1);
    end
    slaveHold = (h > 0);
    stopReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stopReq = 1'b0;
    check(stopEnable && sclPullLow, "R3 enable and scl low", int'({stopEnable, sclPullLow}), 3);
    prevScl = 1'b1; prevSda = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (sdaPullLow && sdaLowAt < 0) sdaLowAt = k;
      if (prevScl && !sclPullLow && sclRelAt < 0) sclRelAt = k;
      if (prevSda && !sdaPullLow && sdaRelAt < 0) sdaRelAt = k;
      if (!stopEnable && stopDetected && doneAt < 0) doneAt = k;
      if (h > 0 && k == n + 1 + h)
        check(stopEnable && sdaPullLow, "R6 waits while scl held", int'(sdaPullLow), 1);
      prevScl = sclPullLow; prevSda = sdaPullLow;
      if (k == n + 2 + h) slaveHold = 1'b0;
      bufWrite = doWrite && (k == 1);
      bufWrData = 8'hA5;
      stopReq = doReq && (k == 3);
      if (doneAt >= 0) break;
      @(negedge clk);
    end
    bufWrite = 1'b0; stopReq = 1'b0; slaveHold = 1'b0;
    check(sdaLowAt == 0, "R3 sda low first", sdaLowAt, 0);
    check(sclRelAt == n + 2, "R4 scl release", sclRelAt, n + 2);
    check(sdaRelAt == 2 * n + 4 + h, "R5 R6 sda release", sdaRelAt, 2 * n + 4 + h);
    check(doneAt == 2 * n + 5 + h, "R7 completion", doneAt, 2 * n + 5 + h);
    check(irqFlag == 1, "R7 irq raised", int'(irqFlag), 1);
    if (doReq) begin
      cyc(2);
      check(stopEnable == 0, "R11 request during stop ignored", int'(stopEnable), 0);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    check({sclPullLow, sdaPullLow, stopEnable, stopDetected, irqFlag, wcolFlag} == 6'b0,
          "R1 reset state", int'({sclPullLow, sdaPullLow, stopEnable, stopDetected, irqFlag, wcolFlag}), 0);
    rstN = 1'b1;
    cyc(2);

    // R2: SCL stays low with no stop request
    pulse(xferDone);
    cyc(6);
    check(sclPullLow == 1 && sdaPullLow == 0, "R2 hold persists", int'({sclPullLow, sdaPullLow}), 2);

    // R4 R5 R6 R7 sweep over reload values, free bus and held SCL
    for (int n = 0; n < 8; n++) begin
      for (int hv = 0; hv < 2; hv++) begin
        pulse(startSeen);
        pulse(irqClear);
        check(stopDetected == 0 && irqFlag == 0, "R8 cleared before run", int'({stopDetected, irqFlag}), 0);
        runStop(n, hv * 3, 1'b0, 1'b0, 1'b1);
      end
    end

    // R8: sticky flags
    cyc(5);
    check(irqFlag == 1 && stopDetected == 1, "R8 flags sticky", int'({irqFlag, stopDetected}), 3);
    pulse(irqClear);
    check(irqFlag == 0 && stopDetected == 1, "R8 irq clear only", int'({irqFlag, stopDetected}), 1);
    pulse(startSeen);
    check(stopDetected == 0, "R8 start clears stop-detected", int'(stopDetected), 0);

    // R9 idle write
    bufWrData = 8'h3C;
    pulse(bufWrite);
    check(bufData == 8'h3C && wcolFlag == 0, "R9 idle write", int'(bufData), 8'h3C);

    // R9 R3 write during stop, request without prior transfer
    runStop(2, 0, 1'b1, 1'b0, 1'b0);
    check(bufData == 8'h3C, "R9 buffer unchanged", int'(bufData), 8'h3C);
    check(wcolFlag == 1, "R9 collision flag", int'(wcolFlag), 1);
    cyc(4);
    check(wcolFlag == 1, "R10 collision sticky", int'(wcolFlag), 1);
    pulse(wcolClear);
    check(wcolFlag == 0, "R10 collision cleared", int'(wcolFlag), 0);

    // R11 repeated request mid-sequence
    runStop(3, 0, 1'b0, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule